// File: doc/BRIEF.md
# Display Controller Register and Frame-Bank Unit

This block is the software-visible register file of a display controller. A host reads and writes eight 32-bit word locations over a plain single-cycle bus. The locations hold the control word, an event/status word, the horizontal and vertical timing words, a combined line/frame length word and two frame-buffer base addresses. The block decodes the control word into individual fields for the timing generator and the pixel fetch logic, which sit outside it.

The block also owns the double-buffering state. On each rising edge of the vertical-sync input, if the display is enabled, it can swap the active frame buffer between base A and base B. It can also swap the active colour-table half between a fixed base and that base with bit 10 set. Each swap, each frame start and each line-buffer underrun latches a sticky event flag. An enabled flag drives the interrupt line. Software clears a flag by writing 1 to it.

The bus moves no data stream, so it has no valid/ready handshake and never applies back-pressure. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational in the cycle where `bus_rd` is high.

Top module: `disp_regbank`

## Requirements
- R1: After reset, every word location reads 0, `irq` is 0, `video_base` is 0 and `clut_base` equals the parameter CLUT_BASE (default 0x800).
- R2: Word addresses on `bus_addr` are: 0 control, 1 status, 2 horizontal timing, 3 vertical timing, 4 lengths, 5 base A, 6 base B. Address 7 reads 0 and ignores writes. `bus_rdata` is 0 whenever `bus_rd` is low.
- R3: The control word keeps only bits 15:0, and bits 31:16 read 0. Field positions: bit0 video enable, bit1 frame-event irq enable, bit2 line irq enable, bit3 frame-bank irq enable, bit4 colour-bank irq enable, bit5 frame-bank swap enable, bit6 colour-bank swap enable, bits 8:7 `vbl_sel`, bits 10:9 `depth_sel`, bit11 pseudo-colour, bits 12..15 polarity of hsync, vsync, csync and blank. Each field appears on its output port.
- R4: The horizontal timing, vertical timing and lengths words store and return all 32 bits as written, and appear on `htiming`, `vtiming` and `lengths`.
- R5: Both base-address words force bits 1:0 to 0, so a written value reads back ANDed with 0xFFFFFFFC.
- R6: Byte lane i of a write (bits 8i+7:8i) changes only when `bus_be[i]` is 1.
- R7: On a rising edge of `vsync_in` with video enable and frame-bank swap enable both 1, the active frame bank toggles. `video_base` shows base B when the bank is 1 and base A when it is 0. Status bit 6 reads the bank.
- R8: On the same condition with colour-bank swap enable, the colour bank toggles. `clut_base` is CLUT_BASE when the bank is 0 and CLUT_BASE | 0x400 when it is 1.
- R9: With video enable 0, or with the corresponding swap enable 0, a vsync edge leaves that bank unchanged.
- R10: Status flags: bit0 is set by each vsync rising edge while video is enabled, bit4 by each frame-bank toggle and bit5 by each colour-bank toggle. A status write with `bus_be[0]`=1 clears each flag whose write bit is 1. If a set and a clear fall in the same cycle, the set wins.
- R11: A pulse on `underrun_in` sets status bit 1, and that bit drives `irq` with no enable.
- R12: `irq` = (bit0 AND control bit1) OR bit1 OR (bit4 AND control bit3) OR (bit5 AND control bit4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| underrun_in | input | 1 | Line-buffer underrun pulse |
| video_base | output | 32 | Active frame-buffer base |
| clut_base | output | 32 | Active colour-table base |
| video_en | output | 1 | Control bit 0 |
| line_irq_en | output | 1 | Control bit 2 |
| vbl_sel | output | 2 | Control bits 8:7 |
| depth_sel | output | 2 | Control bits 10:9 |
| pseudo_col | output | 1 | Control bit 11 |
| hs_pol | output | 1 | Control bit 12 |
| vs_pol | output | 1 | Control bit 13 |
| cs_pol | output | 1 | Control bit 14 |
| bl_pol | output | 1 | Control bit 15 |
| htiming | output | 32 | Horizontal timing word |
| vtiming | output | 32 | Vertical timing word |
| lengths | output | 32 | Line/frame length word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch the vsync-driven state on every cycle:
- a qualified edge always toggles the bank;
- no other cycle ever moves it;
- the frame flag and the underrun flag are always set one cycle after their cause;
- `irq` never rises without a flag;
- `video_base` stays word aligned.

Only the bench scenarios can show that the byte-lane masking, the reserved bits, the write-1-clear encoding and the set-wins collision produce the right read values. The same holds for the interrupt combination across many enable patterns. The bench compares these against a shadow model after directed and seeded random sequences.

// File: rtl/disp_regs_pkg.sv
package disp_regs_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_STORE = 6;

  localparam logic [31:0] CLUT_HALF = 32'h0000_0400;

  // word addresses
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_STAT  = 1;
  localparam int unsigned A_HTIM  = 2;
  localparam int unsigned A_VTIM  = 3;
  localparam int unsigned A_LENS  = 4;
  localparam int unsigned A_BASEA = 5;
  localparam int unsigned A_BASEB = 6;

  // sticky event flag indices inside the bank unit
  localparam int unsigned F_FRAME = 0;
  localparam int unsigned F_UNDER = 1;
  localparam int unsigned F_VBANK = 2;
  localparam int unsigned F_CBANK = 3;
  localparam int unsigned NUM_FLAGS = 4;

  typedef struct packed {
    logic       bl_pol;
    logic       cs_pol;
    logic       vs_pol;
    logic       hs_pol;
    logic       pseudo;
    logic [1:0] depth;
    logic [1:0] vbl;
    logic       cbsw_en;
    logic       vbsw_en;
    logic       cbirq_en;
    logic       vbirq_en;
    logic       lirq_en;
    logic       firq_en;
    logic       video_en;
  } ctrl_t;

  // storage slot to word address: slot 0 is control, slots 1..5 follow status
  function automatic int unsigned slot_addr(input int unsigned slot);
    return (slot == 0) ? A_CTRL : slot + 1;
  endfunction

  function automatic logic [31:0] slot_mask(input int unsigned slot);
    case (slot_addr(slot))
      A_CTRL:           return 32'h0000_FFFF;
      A_BASEA, A_BASEB: return 32'hFFFF_FFFC;
      default:          return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/disp_be_reg.sv
module disp_be_reg #(
  parameter int unsigned W         = 32,
  parameter logic [W-1:0] KEEP_MASK = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   q
);
  localparam int unsigned LANES = W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [7:0] LMASK = KEEP_MASK[i*8 +: 8];
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              byte_q <= '0;
      else if (we && be[i])    byte_q <= wdata[i*8 +: 8] & LMASK;
    end
    assign q[i*8 +: 8] = byte_q;
  end

endmodule

// File: rtl/disp_bank_unit.sv
module disp_bank_unit
  import disp_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vsync_in,
  input  logic                 underrun_in,
  input  logic                 video_en,
  input  logic                 vbsw_en,
  input  logic                 cbsw_en,
  input  logic [NUM_FLAGS-1:0] clr,
  output logic                 vbank,
  output logic                 cbank,
  output logic [NUM_FLAGS-1:0] flags
);
  logic                 vsync_q;
  logic                 frame_edge;
  logic                 vswap, cswap;
  logic [NUM_FLAGS-1:0] set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vsync_q <= 1'b0;
    else        vsync_q <= vsync_in;
  end

  assign frame_edge = vsync_in && !vsync_q && video_en;
  assign vswap      = frame_edge && vbsw_en;
  assign cswap      = frame_edge && cbsw_en;

  always_comb begin
    set          = '0;
    set[F_FRAME] = frame_edge;
    set[F_UNDER] = underrun_in;
    set[F_VBANK] = vswap;
    set[F_CBANK] = cswap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbank <= 1'b0;
      cbank <= 1'b0;
      flags <= '0;
    end else begin
      if (vswap) vbank <= ~vbank;
      if (cswap) cbank <= ~cbank;
      flags <= set | (flags & ~clr);
    end
  end

  // R7
  vbank_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_in && !vsync_q && video_en && vbsw_en) |=> (vbank != $past(vbank)));

  // R9
  vbank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vsync_in && !vsync_q && video_en && vbsw_en) |=> $stable(vbank));

  // R9
  cbank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!video_en || !cbsw_en) |=> $stable(cbank));

  // R10
  frame_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_in && !vsync_q && video_en) |=> flags[F_FRAME]);

  // R11
  under_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_in |=> flags[F_UNDER]);

endmodule

// File: rtl/disp_regbank.sv
module disp_regbank
  import disp_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter logic [31:0] CLUT_BASE = 32'h0000_0800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              vsync_in,
  input  logic              underrun_in,
  output logic [31:0]       video_base,
  output logic [31:0]       clut_base,
  output logic              video_en,
  output logic              line_irq_en,
  output logic [1:0]        vbl_sel,
  output logic [1:0]        depth_sel,
  output logic              pseudo_col,
  output logic              hs_pol,
  output logic              vs_pol,
  output logic              cs_pol,
  output logic              bl_pol,
  output logic [31:0]       htiming,
  output logic [31:0]       vtiming,
  output logic [31:0]       lengths,
  output logic              irq
);
  localparam int unsigned BE_W = WORD_W / 8;

  logic [WORD_W-1:0]    store_q [NUM_STORE];
  ctrl_t                ctrl;
  logic                 vbank, cbank;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] clr;
  logic [WORD_W-1:0]    status_w;
  logic                 stat_wr;

  for (genvar g = 0; g < NUM_STORE; g++) begin : g_store
    localparam int unsigned WADDR = slot_addr(g);
    disp_be_reg #(
      .W         (WORD_W),
      .KEEP_MASK (slot_mask(g))
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_wr && (bus_addr == ADDR_W'(WADDR))),
      .be    (bus_be[BE_W-1:0]),
      .wdata (bus_wdata),
      .q     (store_q[g])
    );
  end

  assign ctrl = ctrl_t'(store_q[0][15:0]);

  assign stat_wr = bus_wr && (bus_addr == ADDR_W'(A_STAT)) && bus_be[0];
  always_comb begin
    clr = '0;
    if (stat_wr) begin
      clr[F_FRAME] = bus_wdata[0];
      clr[F_UNDER] = bus_wdata[1];
      clr[F_VBANK] = bus_wdata[4];
      clr[F_CBANK] = bus_wdata[5];
    end
  end

  disp_bank_unit u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync_in    (vsync_in),
    .underrun_in (underrun_in),
    .video_en    (ctrl.video_en),
    .vbsw_en     (ctrl.vbsw_en),
    .cbsw_en     (ctrl.cbsw_en),
    .clr         (clr),
    .vbank       (vbank),
    .cbank       (cbank),
    .flags       (flags)
  );

  always_comb begin
    status_w    = '0;
    status_w[0] = flags[F_FRAME];
    status_w[1] = flags[F_UNDER];
    status_w[4] = flags[F_VBANK];
    status_w[5] = flags[F_CBANK];
    status_w[6] = vbank;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(A_CTRL):  bus_rdata = store_q[0];
        ADDR_W'(A_STAT):  bus_rdata = status_w;
        ADDR_W'(A_HTIM):  bus_rdata = store_q[1];
        ADDR_W'(A_VTIM):  bus_rdata = store_q[2];
        ADDR_W'(A_LENS):  bus_rdata = store_q[3];
        ADDR_W'(A_BASEA): bus_rdata = store_q[4];
        ADDR_W'(A_BASEB): bus_rdata = store_q[5];
        default:          bus_rdata = '0;
      endcase
    end
  end

  assign video_base  = vbank ? store_q[5] : store_q[4];
  assign clut_base   = cbank ? (CLUT_BASE | CLUT_HALF) : CLUT_BASE;
  assign video_en    = ctrl.video_en;
  assign line_irq_en = ctrl.lirq_en;
  assign vbl_sel     = ctrl.vbl;
  assign depth_sel   = ctrl.depth;
  assign pseudo_col  = ctrl.pseudo;
  assign hs_pol      = ctrl.hs_pol;
  assign vs_pol      = ctrl.vs_pol;
  assign cs_pol      = ctrl.cs_pol;
  assign bl_pol      = ctrl.bl_pol;
  assign htiming     = store_q[1];
  assign vtiming     = store_q[2];
  assign lengths     = store_q[3];

  assign irq = (flags[F_FRAME] && ctrl.firq_en) || flags[F_UNDER] ||
               (flags[F_VBANK] && ctrl.vbirq_en) || (flags[F_CBANK] && ctrl.cbirq_en);

  // R12
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));

  // R5
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    video_base[1:0] == 2'b00);

  // R11
  under_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_in |=> irq);

endmodule

// File: tb/disp_regbank_tb.sv
`timescale 1ns/1ps
module disp_regbank_tb_top;
  localparam logic [31:0] CLUT = 32'h0000_0800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        vsync_in = 1'b0, underrun_in = 1'b0;
  logic [31:0] video_base, clut_base, htiming, vtiming, lengths;
  logic        video_en, line_irq_en, pseudo_col, hs_pol, vs_pol, cs_pol, bl_pol, irq;
  logic [1:0]  vbl_sel, depth_sel;

  int n_cmp = 0;
  int n_bad = 0;

  // shadow model
  logic [31:0] m_reg [8];
  logic        m_vbank, m_cbank, m_ff, m_fu, m_fv, m_fc;

  always #5 clk = ~clk;

  disp_regbank #(.ADDR_W(3), .CLUT_BASE(CLUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .vsync_in(vsync_in), .underrun_in(underrun_in),
    .video_base(video_base), .clut_base(clut_base), .video_en(video_en),
    .line_irq_en(line_irq_en), .vbl_sel(vbl_sel), .depth_sel(depth_sel),
    .pseudo_col(pseudo_col), .hs_pol(hs_pol), .vs_pol(vs_pol), .cs_pol(cs_pol),
    .bl_pol(bl_pol), .htiming(htiming), .vtiming(vtiming), .lengths(lengths),
    .irq(irq)
  );

  function automatic logic [31:0] keep_mask(input int a);
    case (a)
      0:       return 32'h0000_FFFF;
      5, 6:    return 32'hFFFF_FFFC;
      2, 3, 4: return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d,
                                        input logic [3:0] be, input logic [31:0] m);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = d[i*8 +: 8] & m[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    if (a == 1) return {25'b0, m_vbank, m_fc, m_fv, 2'b00, m_fu, m_ff};
    return m_reg[a];
  endfunction

  function automatic logic exp_irq();
    return (m_ff & m_reg[0][1]) | m_fu | (m_fv & m_reg[0][3]) | (m_fc & m_reg[0][4]);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_clear(input logic [3:0] be, input logic [31:0] d);
    if (be[0]) begin
      if (d[0]) m_ff = 1'b0;
      if (d[1]) m_fu = 1'b0;
      if (d[4]) m_fv = 1'b0;
      if (d[5]) m_fc = 1'b0;
    end
  endtask

  task automatic model_edge();
    if (m_reg[0][0]) begin
      m_ff = 1'b1;
      if (m_reg[0][5]) begin m_vbank = ~m_vbank; m_fv = 1'b1; end
      if (m_reg[0][6]) begin m_cbank = ~m_cbank; m_fc = 1'b1; end
    end
  endtask

  task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[2:0]; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 1) model_clear(be, d);
    else m_reg[a] = merge(m_reg[a], d, be, keep_mask(a));
  endtask

  task automatic vsync_pulse();
    @(negedge clk); vsync_in = 1'b1;
    @(negedge clk); vsync_in = 1'b0;
    model_edge();
  endtask

  // vsync edge and a flag clear land on the same clock edge
  task automatic vsync_with_clear(input logic [31:0] d);
    @(negedge clk);
    vsync_in = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_be = 4'h1; bus_wdata = d;
    @(negedge clk);
    vsync_in = 1'b0; bus_wr = 1'b0;
    model_clear(4'h1, d);
    model_edge();
  endtask

  task automatic underrun_pulse();
    @(negedge clk); underrun_in = 1'b1;
    @(negedge clk); underrun_in = 1'b0;
    m_fu = 1'b1;
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a[2:0];
      #1;
      chk({tag, " R2 read"}, bus_rdata, exp_rd(a));
      @(posedge clk); #1;
      bus_rd = 1'b0;
    end
    #1;
    chk({tag, " R2 idle rdata"}, bus_rdata, 32'h0);
    chk({tag, " R7 video_base"}, video_base, m_vbank ? m_reg[6] : m_reg[5]);
    chk({tag, " R8 clut_base"}, clut_base, m_cbank ? (CLUT | 32'h400) : CLUT);
    chk({tag, " R12 irq"}, {31'b0, irq}, {31'b0, exp_irq()});
    chk({tag, " R3 fields"},
        {20'b0, bl_pol, cs_pol, vs_pol, hs_pol, pseudo_col, depth_sel, vbl_sel, line_irq_en, video_en},
        {20'b0, m_reg[0][15:7], m_reg[0][2], m_reg[0][0]});
    chk({tag, " R4 timing outs"}, htiming ^ vtiming ^ lengths, m_reg[2] ^ m_reg[3] ^ m_reg[4]);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_vbank = 0; m_cbank = 0; m_ff = 0; m_fu = 0; m_fv = 0; m_fc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    check_all("R1 reset");

    // R3: reserved upper half of control
    wr(0, 4'hF, 32'hFFFF_FFFF);
    check_all("R3 all ones");
    wr(0, 4'hF, 32'h0000_0000);

    // R4: full-width timing words
    wr(2, 4'hF, 32'hA5A5_5A5A);
    wr(3, 4'hF, 32'h3333_CCCC);
    wr(4, 4'hF, 32'hFFFF_0001);
    check_all("R4 timing");

    // R5: base alignment
    wr(5, 4'hF, 32'hFFFF_FFFF);
    wr(6, 4'hF, 32'h1234_5677);
    check_all("R5 bases");

    // R6: byte lanes
    wr(2, 4'b0101, 32'h0000_0000);
    wr(3, 4'b1000, 32'h7700_0000);
    check_all("R6 lanes");

    // R2: unmapped word
    wr(7, 4'hF, 32'hDEAD_BEEF);
    check_all("R2 addr7");

    // R9: swap enabled, video off -> no toggle, no frame flag
    wr(0, 4'hF, 32'h0000_0060);
    vsync_pulse();
    check_all("R9 video off");
    // video on, swaps off
    wr(0, 4'hF, 32'h0000_0001);
    vsync_pulse();
    check_all("R9 swaps off");

    // R7 R8: toggling over three frames with all irq enables
    wr(0, 4'hF, 32'h0000_007F);
    for (int k = 0; k < 3; k++) begin
      vsync_pulse();
      check_all("R7 R8 toggle");
    end

    // R10: write-1-clear of frame and bank flags
    wr(1, 4'hF, 32'h0000_0031);
    check_all("R10 w1c");
    // clear without byte 0 enable has no effect
    vsync_pulse();
    wr(1, 4'hE, 32'hFFFF_FFFF);
    check_all("R10 be0 gate");
    // R10: set wins over clear
    wr(1, 4'h1, 32'h0000_0033);
    vsync_with_clear(32'h0000_0031);
    check_all("R10 set wins");

    // R11: underrun with every enable off
    wr(1, 4'h1, 32'h0000_00FF);
    wr(0, 4'hF, 32'h0000_0000);
    underrun_pulse();
    check_all("R11 underrun");
    wr(1, 4'h1, 32'h0000_0002);
    check_all("R11 cleared");

    // R12: flags present but enables off
    wr(0, 4'hF, 32'h0000_0061);
    vsync_pulse();
    check_all("R12 masked");

    // seeded random mix
    for (int it = 0; it < 250; it++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0, 1: wr($urandom_range(0, 7), 4'($urandom), $urandom);
        2:    wr(0, 4'h1, 32'($urandom_range(0, 255)));
        3:    vsync_pulse();
        4:    underrun_pulse();
        default: wr(1, 4'($urandom), $urandom);
      endcase
      if (it % 10 == 9) check_all("R6 R10 R12 random");
    end
    check_all("R7 R12 random end");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule